// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block walks one transfer descriptor and turns it into a stream of memory requests. Each request carries a source byte address, a destination byte address and a byte length. A transfer has three nested dimensions. An array is a run of A contiguous bytes. A frame is B arrays. A block is C frames. Each dimension has its own signed stride, and the source and destination sides keep separate strides. Either side can be pinned to a fixed address, for example to reach a peripheral FIFO. The 3-bit width code for that access is passed out alongside the requests.

Software presents the descriptor and pulses `load_i` while the sequencer is idle. This arms the sequencer. From then on, every pulse on `sync_i` releases one portion of the transfer:
- In array-synchronized mode, a pulse releases one array.
- In frame-synchronized mode, a pulse releases one whole frame of back-to-back array requests.

After the last array of the last frame, the block may emit a one-cycle completion pulse carrying a completion code, and it returns to idle. A sync pulse that arrives while requests are still being issued is reported as missed and is discarded.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, `req_valid_o`, `active_o`, `done_o` and `missed_o` are all 0.
- R2: In idle, a `load_i` pulse captures the descriptor and sets `active_o`. A `sync_i` pulse in idle produces no request and no missed pulse.
- R3: Array-synchronized mode is selected by option bit 2 = 0. In this mode each accepted sync pulse yields exactly one request of length A, where A is the low 16 bits of `cnt_ab_i`. Within a frame, each side's address moves by that side's signed array stride. The source stride is the low half of `bidx_i` and the destination stride is the high half.
- R4: In array-synchronized mode, when the frame count runs down after the last array of a frame, it is reloaded from `rld_i` and the block count decrements. The next array's address is the last array's address plus that side's signed frame stride. The source frame stride is the low half of `cidx_i` and the destination frame stride is the high half.
- R5: Frame-synchronized mode is selected by option bit 2 = 1. In this mode each sync pulse yields B back-to-back requests, where B is the high 16 bits of `cnt_ab_i`. The next frame starts at the current frame's start address plus the frame stride. The frame count is reloaded from B, not from `rld_i`.
- R6: Option bit 0 fixes the source address and option bit 1 fixes the destination address; a fixed side never advances. `req_fifow_o` equals option bits 6:4 when either side is fixed, and 0 otherwise.
- R7: A request whose `req_ready_i` is low holds `req_valid_o` and both addresses unchanged.
- R8: The cycle after the final request is accepted, `done_o` pulses for one cycle with `done_code_o` equal to option bits 12:7, but only when option bit 3 is set. Either way, `active_o` returns to 0.
- R9: A sync pulse while requests are being issued produces a one-cycle `missed_o` pulse and no additional request.
- R10: A descriptor with A equal to the length, B = 1, C = 1, both array strides equal to A and both frame strides zero yields one request that copies the whole range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture descriptor (used in idle only) |
| opt_i | input | 13 | Options: [0] source fixed, [1] destination fixed, [2] frame-sync, [3] completion enable, [6:4] FIFO width, [12:7] completion code |
| src_i | input | 32 | Source start address |
| cnt_ab_i | input | 32 | [31:16] arrays per frame B, [15:0] bytes per array A |
| dst_i | input | 32 | Destination start address |
| bidx_i | input | 32 | [31:16] destination array stride, [15:0] source array stride (signed) |
| rld_i | input | 16 | Frame-count reload for array-synchronized mode |
| cidx_i | input | 32 | [31:16] destination frame stride, [15:0] source frame stride (signed) |
| ccnt_i | input | 16 | Frames per block C |
| sync_i | input | 1 | Synchronization event |
| req_ready_i | input | 1 | Memory port accepts request |
| req_valid_o | output | 1 | Request valid |
| req_src_o | output | 32 | Request source address |
| req_dst_o | output | 32 | Request destination address |
| req_len_o | output | 16 | Request length in bytes |
| req_fifow_o | output | 3 | FIFO access width for a fixed side |
| active_o | output | 1 | Descriptor loaded and not finished |
| done_o | output | 1 | Completion pulse |
| done_code_o | output | 6 | Completion code |
| missed_o | output | 1 | Sync event dropped |

## Verification
The embedded properties check several rules on every cycle:
- a stalled request keeps its addresses;
- a fixed side never moves;
- a missed pulse only follows an issuing cycle;
- the completion pulse only appears once the block is back in idle;
- the frame counter is never at zero when a request is accepted.

The address sequence itself can only be shown by the bench's scenarios. These compare every request against an independently computed walk of the descriptor. That walk covers the frame-boundary arithmetic in both sync modes, the reload-versus-B distinction, negative strides and the suppressed completion pulse.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  localparam int CODE_W = 6;
  localparam int FW_W   = 3;
  localparam int OPT_W  = 4 + FW_W + CODE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ISSUE = 2'd2
  } seq_state_e;

  // bit 0 is the LSB (src_fixed)
  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [FW_W-1:0]   fifo_w;
    logic              cmpl_en;
    logic              frame_sync;
    logic              dst_fixed;
    logic              src_fixed;
  } opt_t;

endpackage

// File: rtl/dma3d_counter.sv
module dma3d_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  input  logic [CNT_W-1:0] c_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic             frame_sync_i,
  input  logic             adv_i,
  output logic             arr_last_o,
  output logic             blk_last_o,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] a_q, b_q, rld_q, bcnt_q, ccnt_q;
  logic             fs_q;

  assign arr_last_o = (bcnt_q == ONE);
  assign blk_last_o = arr_last_o && (ccnt_q == ONE);
  assign len_o      = a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      rld_q  <= '0;
      bcnt_q <= '0;
      ccnt_q <= '0;
      fs_q   <= 1'b0;
    end else if (load_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      rld_q  <= rld_i;
      bcnt_q <= b_i;
      ccnt_q <= c_i;
      fs_q   <= frame_sync_i;
    end else if (adv_i) begin
      if (bcnt_q == ONE) begin
        if (ccnt_q != ONE) begin
          bcnt_q <= fs_q ? b_q : rld_q;
          ccnt_q <= ccnt_q - ONE;
        end
      end else begin
        bcnt_q <= bcnt_q - ONE;
      end
    end
  end

  // R4: the frame counter is never exhausted when an array is accepted
  assert_bcnt_live_R4: assert property (@(posedge clk) disable iff (rst)
    adv_i |-> (bcnt_q != '0 && ccnt_q != '0));

endmodule

// File: rtl/dma3d_side.sv
module dma3d_side #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              fixed_i,
  input  logic              frame_sync_i,
  input  logic [IDX_W-1:0]  arr_stride_i,
  input  logic [IDX_W-1:0]  frm_stride_i,
  input  logic              adv_i,
  input  logic              arr_last_i,
  input  logic              blk_last_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] cur_q, fstart_q, astep_q, fstep_q;
  logic              fixed_q, fs_q;
  logic [ADDR_W-1:0] frm_next;

  assign addr_o   = cur_q;
  assign frm_next = (fs_q ? fstart_q : cur_q) + fstep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      fstart_q <= '0;
      astep_q  <= '0;
      fstep_q  <= '0;
      fixed_q  <= 1'b0;
      fs_q     <= 1'b0;
    end else if (load_i) begin
      cur_q    <= base_i;
      fstart_q <= base_i;
      astep_q  <= ADDR_W'($signed(arr_stride_i));
      fstep_q  <= ADDR_W'($signed(frm_stride_i));
      fixed_q  <= fixed_i;
      fs_q     <= frame_sync_i;
    end else if (adv_i && !fixed_q && !blk_last_i) begin
      if (!arr_last_i) begin
        cur_q <= cur_q + astep_q;
      end else begin
        cur_q    <= frm_next;
        fstart_q <= frm_next;
      end
    end
  end

  // R6: a fixed side keeps its address until the next descriptor load
  assert_fixed_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (fixed_q && !load_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [OPT_W-1:0]    opt_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [2*CNT_W-1:0]  cnt_ab_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic [2*IDX_W-1:0]  bidx_i,
  input  logic [CNT_W-1:0]    rld_i,
  input  logic [2*IDX_W-1:0]  cidx_i,
  input  logic [CNT_W-1:0]    ccnt_i,
  input  logic                sync_i,
  input  logic                req_ready_i,
  output logic                req_valid_o,
  output logic [ADDR_W-1:0]   req_src_o,
  output logic [ADDR_W-1:0]   req_dst_o,
  output logic [CNT_W-1:0]    req_len_o,
  output logic [FW_W-1:0]     req_fifow_o,
  output logic                active_o,
  output logic                done_o,
  output logic [CODE_W-1:0]   done_code_o,
  output logic                missed_o
);

  localparam int NSIDE = 2;

  seq_state_e  state_q;
  opt_t        opt_in, opt_q;
  logic        ld, fire, ev_end, arr_last, blk_last;
  logic [ADDR_W-1:0] side_base   [NSIDE];
  logic              side_fixed  [NSIDE];
  logic [IDX_W-1:0]  side_astr   [NSIDE];
  logic [IDX_W-1:0]  side_fstr   [NSIDE];
  logic [ADDR_W-1:0] side_addr   [NSIDE];

  assign opt_in   = opt_t'(opt_i);
  assign ld       = (state_q == ST_IDLE) && load_i;
  assign fire     = req_valid_o && req_ready_i;
  assign ev_end   = opt_q.frame_sync ? arr_last : 1'b1;
  assign active_o = (state_q != ST_IDLE);

  // side 0 = source (low halves), side 1 = destination (high halves)
  assign side_base[0]  = src_i;
  assign side_base[1]  = dst_i;
  assign side_fixed[0] = opt_in.src_fixed;
  assign side_fixed[1] = opt_in.dst_fixed;

  generate
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
      assign side_astr[g] = bidx_i[g*IDX_W +: IDX_W];
      assign side_fstr[g] = cidx_i[g*IDX_W +: IDX_W];
      dma3d_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_side (
        .clk          (clk),
        .rst          (rst),
        .load_i       (ld),
        .base_i       (side_base[g]),
        .fixed_i      (side_fixed[g]),
        .frame_sync_i (opt_in.frame_sync),
        .arr_stride_i (side_astr[g]),
        .frm_stride_i (side_fstr[g]),
        .adv_i        (fire),
        .arr_last_i   (arr_last),
        .blk_last_i   (blk_last),
        .addr_o       (side_addr[g])
      );
    end
  endgenerate

  assign req_src_o = side_addr[0];
  assign req_dst_o = side_addr[1];

  dma3d_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .load_i       (ld),
    .a_i          (cnt_ab_i[CNT_W-1:0]),
    .b_i          (cnt_ab_i[2*CNT_W-1:CNT_W]),
    .c_i          (ccnt_i),
    .rld_i        (rld_i),
    .frame_sync_i (opt_in.frame_sync),
    .adv_i        (fire),
    .arr_last_o   (arr_last),
    .blk_last_o   (blk_last),
    .len_o        (req_len_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      opt_q       <= '0;
      req_valid_o <= 1'b0;
      req_fifow_o <= '0;
      done_o      <= 1'b0;
      done_code_o <= '0;
      missed_o    <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      missed_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            opt_q       <= opt_in;
            req_fifow_o <= (opt_in.src_fixed || opt_in.dst_fixed) ? opt_in.fifo_w : '0;
            state_q     <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (sync_i) begin
            req_valid_o <= 1'b1;
            state_q     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (sync_i) missed_o <= 1'b1;
          if (fire && ev_end) begin
            req_valid_o <= 1'b0;
            if (blk_last) begin
              state_q <= ST_IDLE;
              if (opt_q.cmpl_en) begin
                done_o      <= 1'b1;
                done_code_o <= opt_q.code;
              end
            end else begin
              state_q <= ST_ARMED;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_src_o) && $stable(req_dst_o)));

  assert_missed_src_R9: assert property (@(posedge clk) disable iff (rst)
    missed_o |-> $past(state_q == ST_ISSUE));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!active_o && !req_valid_o));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> !req_valid_o);

endmodule

// File: tb/dma3d_seq_bench.sv
`timescale 1ns/1ps
module dma3d_seq_bench;

  typedef struct packed {
    logic ab; logic sc; logic dc; logic cie;
    logic [2:0] fw; logic [5:0] code;
    logic [15:0] a, b, c, rld;
    logic [31:0] src, dst;
    logic [15:0] sbi, dbi, sci, dci;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    // R10 contiguous copy
    '{1'b1,1'b0,1'b0,1'b1,3'd0,6'h05,16'd64,16'd1,16'd1,16'd0,32'h1000,32'h2000,16'd64,16'd64,16'd0,16'd0},
    // R3/R4 array-sync with reload and negative dst stride
    '{1'b0,1'b0,1'b0,1'b1,3'd0,6'h2A,16'd4,16'd3,16'd2,16'd2,32'h100,32'h8000,16'd8,16'hFFFC,16'h40,16'h100},
    // R5 frame-sync, reload field must be ignored
    '{1'b1,1'b0,1'b0,1'b1,3'd0,6'h11,16'd8,16'd3,16'd3,16'd7,32'h3000,32'h5000,16'd16,16'd8,16'h200,16'hFFC0},
    // R6/R8 fixed destination, completion disabled
    '{1'b0,1'b0,1'b1,1'b0,3'b101,6'h07,16'd2,16'd2,16'd2,16'd2,32'h600,32'h4000_0000,16'd2,16'h10,16'd2,16'h20},
    // R6 fixed source, frame-sync
    '{1'b1,1'b1,1'b0,1'b1,3'b010,6'h3F,16'd4,16'd2,16'd1,16'd1,32'h7000_0000,32'h900,16'h20,16'd4,16'd0,16'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic load_i = 1'b0, sync_i = 1'b0, req_ready_i = 1'b1;
  logic [12:0] opt_i = '0;
  logic [31:0] src_i = '0, cnt_ab_i = '0, dst_i = '0, bidx_i = '0, cidx_i = '0;
  logic [15:0] rld_i = '0, ccnt_i = '0;
  logic req_valid_o, active_o, done_o, missed_o;
  logic [31:0] req_src_o, req_dst_o;
  logic [15:0] req_len_o;
  logic [2:0]  req_fifow_o;
  logic [5:0]  done_code_o;

  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dma3d_seq u_dma3d_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .opt_i(opt_i), .src_i(src_i),
    .cnt_ab_i(cnt_ab_i), .dst_i(dst_i), .bidx_i(bidx_i), .rld_i(rld_i),
    .cidx_i(cidx_i), .ccnt_i(ccnt_i), .sync_i(sync_i), .req_ready_i(req_ready_i),
    .req_valid_o(req_valid_o), .req_src_o(req_src_o), .req_dst_o(req_dst_o),
    .req_len_o(req_len_o), .req_fifow_o(req_fifow_o), .active_o(active_o),
    .done_o(done_o), .done_code_o(done_code_o), .missed_o(missed_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic drive_desc(input vec_t v);
    opt_i    = {v.code, v.fw, v.cie, v.ab, v.dc, v.sc};
    src_i    = v.src;
    dst_i    = v.dst;
    cnt_ab_i = {v.b, v.a};
    bidx_i   = {v.dbi, v.sbi};
    cidx_i   = {v.dci, v.sci};
    rld_i    = v.rld;
    ccnt_i   = v.c;
    load_i   = 1'b1;
    @(negedge clk);
    load_i   = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] es, ed, fs, fd;
    int bl, cl, nreq;
    bit fin;
    es = v.src; ed = v.dst; fs = v.src; fd = v.dst;
    bl = int'(v.b); cl = int'(v.c); fin = 1'b0;
    drive_desc(v);
    chk("R2", "active after load", {31'd0, active_o}, 32'd1);
    while (!fin) begin
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      nreq = v.ab ? bl : 1;
      for (int k = 0; k < nreq; k++) begin
        chk(v.ab ? "R5" : "R3", "req valid", {31'd0, req_valid_o}, 32'd1);
        chk(v.sc ? "R6" : (v.ab ? "R5" : "R4"), "src addr", req_src_o, es);
        chk(v.dc ? "R6" : (v.ab ? "R5" : "R4"), "dst addr", req_dst_o, ed);
        chk("R10", "length", {16'd0, req_len_o}, {16'd0, v.a});
        chk("R6", "fifo width", {29'd0, req_fifow_o}, (v.sc || v.dc) ? {29'd0, v.fw} : 32'd0);
        if (bl > 1) begin
          bl--;
          if (!v.sc) es = es + sx(v.sbi);
          if (!v.dc) ed = ed + sx(v.dbi);
        end else if (cl > 1) begin
          cl--;
          bl = v.ab ? int'(v.b) : int'(v.rld);
          if (!v.sc) begin es = (v.ab ? fs : es) + sx(v.sci); fs = es; end
          if (!v.dc) begin ed = (v.ab ? fd : ed) + sx(v.dci); fd = ed; end
        end else begin
          fin = 1'b1;
        end
        @(negedge clk);
      end
      chk(v.ab ? "R5" : "R3", "event ends", {31'd0, req_valid_o}, 32'd0);
    end
    chk("R8", "done pulse", {31'd0, done_o}, {31'd0, v.cie});
    if (v.cie) chk("R8", "done code", {26'd0, done_code_o}, {26'd0, v.code});
    chk("R8", "idle after block", {31'd0, active_o}, 32'd0);
    @(negedge clk);
    chk("R8", "done one cycle", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid at reset", {31'd0, req_valid_o}, 32'd0);
    chk("R1", "active at reset", {31'd0, active_o}, 32'd0);
    chk("R1", "done at reset", {31'd0, done_o}, 32'd0);
    chk("R1", "missed at reset", {31'd0, missed_o}, 32'd0);

    // R2: sync while idle is ignored
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    @(negedge clk);
    chk("R2", "idle sync no request", {31'd0, req_valid_o}, 32'd0);
    chk("R2", "idle sync no missed", {31'd0, missed_o}, 32'd0);
    chk("R2", "idle sync stays idle", {31'd0, active_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7 + R9: stall with a sync pulse arriving mid-issue
    drive_desc('{1'b1,1'b0,1'b0,1'b1,3'd0,6'h09,16'd4,16'd2,16'd1,16'd0,
                 32'hA000,32'hB000,16'd4,16'd4,16'd0,16'd0});
    req_ready_i = 1'b0;
    sync_i = 1'b1;
    @(negedge clk);
    chk("R7", "valid under stall", {31'd0, req_valid_o}, 32'd1);
    chk("R7", "src under stall", req_src_o, 32'hA000);
    @(negedge clk);
    sync_i = 1'b0;
    chk("R9", "missed pulse", {31'd0, missed_o}, 32'd1);
    chk("R7", "src still held", req_src_o, 32'hA000);
    chk("R7", "dst still held", req_dst_o, 32'hB000);
    @(negedge clk);
    chk("R9", "missed one cycle", {31'd0, missed_o}, 32'd0);
    req_ready_i = 1'b1;
    @(negedge clk);
    chk("R7", "second array src", req_src_o, 32'hA004);
    @(negedge clk);
    chk("R8", "done after stall", {31'd0, done_o}, 32'd1);
    chk("R8", "done code after stall", {26'd0, done_code_o}, 32'h09);
    @(negedge clk);
    chk("R9", "no extra request", {31'd0, req_valid_o}, 32'd0);
    chk("R9", "back to idle", {31'd0, active_o}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule